// File: doc/BRIEF.md
# Serial Channel Status Flag Word

This block gathers the event pulses and live levels of a multi-mode serial channel into one 16-bit status word. The transmitter, the receiver, a receive time-out counter, a LIN frame engine, a smart-card retry counter, a DMA channel and the four modem-control input pins all feed it. Other logic in the channel produces those events. Here they arrive only as single-cycle pulses or as levels.

Three clearing disciplines share the word. Level flags follow live conditions. Sticky error flags hold until a reset-status command strobe. Modem-pin change flags clear when the word is read. The non-acknowledge flag and the time-out flag each have a clear strobe of their own. One bit position changes its meaning with the operating mode.

A host reads the word by pulsing `rd_en`. The word is then captured into `rd_data` on that clock edge. `status_q` is a registered copy of the word that updates every cycle.

Top module: `ser_status_word`

## Requirements
- R1: Each modem pin (`modem_pins[0..3]`, reported at status bits 12..15) passes through a two-stage synchronizer. A transition on a pin sets that pin's change flag. A read (`rd_en`) clears the flag, unless a change is detected in the same cycle as the read, in which case the flag stays set.
- R2: The sticky flags are overrun (bit 2), framing (bit 3, set by `stop_low_p`), break (bit 1), parity (bit 4), LIN identifier (bit 10), LIN complete (bit 11) and repetition/underrun (bit 7). Each sets on its event pulse and clears only on `cmd_rst_sta`. If an event pulse and `cmd_rst_sta` arrive in the same cycle, the flag is set.
- R3: The non-acknowledge flag (bit 9) sets on `nack_p`. It clears only on `cmd_rst_nack`, and `cmd_rst_sta` leaves it unchanged.
- R4: Bit 7 records `iter_p` when `spi_slave` is 0 and `unre_p` when `spi_slave` is 1. The pulse that is not selected is ignored.
- R5: When `mdrop` is 1, bit 4 sets on `addr_char_p` and ignores `par_err_p`. When `mdrop` is 0, bit 4 sets on `par_err_p` and ignores `addr_char_p`.
- R6: The time-out flag (bit 5) sets on `tmo_expire_p` and clears on `cmd_sttto`. `cmd_rst_sta` does not clear it. While `tmo_zero` is 1 the flag reads 0.
- R7: Transmitter ready (bit 0) equals `tx_en & !thr_full & !brk_pend`.
- R8: Transmitter empty (bit 6) equals `tx_en & !thr_full & !tsr_busy`.
- R9: Buffer full (bit 8) is a live copy of `dma_full`, delayed by the single output register.
- R10: `rd_data` captures the word that was current in the cycle `rd_en` was high, taken before that read cleared any change flags. When `rd_en` is low, `rd_data` holds its value.
- R11: After reset, `status_q` and `rd_data` are zero. Bits 13..15 of an unused layout slot do not exist: all 16 bits carry the meanings above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Status read strobe; captures the word and clears change flags |
| cmd_rst_sta | input | 1 | Reset-status command strobe |
| cmd_rst_nack | input | 1 | Reset non-acknowledge command strobe |
| cmd_sttto | input | 1 | Start time-out command strobe; clears the time-out flag |
| spi_slave | input | 1 | Operating mode: SPI slave |
| mdrop | input | 1 | Operating mode: multidrop |
| tx_en | input | 1 | Transmitter enabled |
| thr_full | input | 1 | Holding register occupied |
| tsr_busy | input | 1 | Transmit shift register occupied |
| brk_pend | input | 1 | Start-break request pending |
| par_err_p | input | 1 | Parity error pulse |
| addr_char_p | input | 1 | Received parity bit of 1 (multidrop address) pulse |
| stop_low_p | input | 1 | Stop bit sampled low pulse |
| ovr_p | input | 1 | Overrun pulse |
| brk_p | input | 1 | Break received or ended pulse |
| tmo_expire_p | input | 1 | Time-out counter expired pulse |
| tmo_zero | input | 1 | Programmed time-out value is zero |
| iter_p | input | 1 | Maximum repetitions reached pulse |
| unre_p | input | 1 | SPI slave transmit underrun pulse |
| nack_p | input | 1 | Non-acknowledge pulse |
| lin_id_p | input | 1 | LIN identifier sent or received pulse |
| lin_done_p | input | 1 | LIN transfer complete pulse |
| dma_full | input | 1 | DMA buffer-full level |
| modem_pins | input | 4 | Asynchronous CTS, DCD, DSR, RI pins |
| status_q | output | 16 | Registered status word, updated every cycle |
| rd_data | output | 16 | Status word captured at the last read |

## Verification
The bench targets the cycles in which a set event and a clear arrive together. A pin change that lands on a read, and an error pulse that lands on a reset-status command, must both leave their flag at 1. A design that gave priority to the clear would lose the event without trace.

The bench also sends `cmd_rst_sta` while the non-acknowledge and time-out flags are set. If the general clear reached either of them, that flag would drop early.

In each operating mode it drives the pulse that the mode should ignore. A wrong mode select would then raise bit 7 or bit 4. Full sweeps of the transmitter inputs expose a ready or empty flag that ignores the enable, the break request or the shift register.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
  localparam int SW_W    = 16;
  localparam int NPINS   = 4;
  // status word bit positions
  localparam int B_TXRDY   = 0;
  localparam int B_BRK     = 1;
  localparam int B_OVR     = 2;
  localparam int B_FRM     = 3;
  localparam int B_PAR     = 4;
  localparam int B_TMO     = 5;
  localparam int B_TXEMPTY = 6;
  localparam int B_REP     = 7;
  localparam int B_BUFFUL  = 8;
  localparam int B_NACK    = 9;
  localparam int B_LID     = 10;
  localparam int B_LDONE   = 11;
  localparam int B_CHG0    = 12;
  // sticky bank slots
  localparam int S_PAR    = 0;
  localparam int S_FRM    = 1;
  localparam int S_OVR    = 2;
  localparam int S_BRK    = 3;
  localparam int S_TMO    = 4;
  localparam int S_REP    = 5;
  localparam int S_NACK   = 6;
  localparam int S_LID    = 7;
  localparam int S_LDONE  = 8;
  localparam int N_STICKY = 9;
endpackage

// File: rtl/ssw_modem_chg.sv
module ssw_modem_chg #(
  parameter int NP     = 4,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] pins,
  input  logic          rd_en,
  output logic [NP-1:0] chg_o
);
  logic [NP-1:0] sync_q [STAGES];
  logic [NP-1:0] last_q;
  logic [NP-1:0] det;
  logic [NP-1:0] chg_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= '0;
    else     sync_q[0] <= pins;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= '0;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign det = sync_q[STAGES-1] ^ last_q;

  generate
    for (genvar i = 0; i < NP; i++) begin : g_chg
      always_ff @(posedge clk) begin
        if (rst) chg_q[i] <= 1'b0;
        else     chg_q[i] <= det[i] | (chg_q[i] & ~rd_en);
      end
      AST_CHG_READ_CLR: assert property (@(posedge clk) disable iff (rst)
        rd_en && !det[i] |=> !chg_q[i]); // R1
      AST_CHG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        det[i] |=> chg_q[i]); // R1
    end
  endgenerate

  assign chg_o = chg_q;
endmodule

// File: rtl/ssw_sticky_bank.sv
module ssw_sticky_bank #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) flag_q[i] <= 1'b0;
        else     flag_q[i] <= set_i[i] | (flag_q[i] & ~clr_i[i]);
      end
      AST_STICKY_CLR: assert property (@(posedge clk) disable iff (rst)
        clr_i[i] && !set_i[i] |=> !flag_q[i]); // R2
      AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        flag_q[i] && !clr_i[i] |=> flag_q[i]); // R2
    end
  endgenerate

  assign flag_o = flag_q;
endmodule

// File: rtl/ssw_tx_level.sv
module ssw_tx_level (
  input  logic tx_en,
  input  logic thr_full,
  input  logic tsr_busy,
  input  logic brk_pend,
  output logic txrdy,
  output logic txempty
);
  always_comb begin
    txrdy   = tx_en & ~thr_full & ~brk_pend;
    txempty = tx_en & ~thr_full & ~tsr_busy;
  end
endmodule

// File: rtl/ser_status_word.sv
module ser_status_word
  import ssw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             cmd_rst_sta,
  input  logic             cmd_rst_nack,
  input  logic             cmd_sttto,
  input  logic             spi_slave,
  input  logic             mdrop,
  input  logic             tx_en,
  input  logic             thr_full,
  input  logic             tsr_busy,
  input  logic             brk_pend,
  input  logic             par_err_p,
  input  logic             addr_char_p,
  input  logic             stop_low_p,
  input  logic             ovr_p,
  input  logic             brk_p,
  input  logic             tmo_expire_p,
  input  logic             tmo_zero,
  input  logic             iter_p,
  input  logic             unre_p,
  input  logic             nack_p,
  input  logic             lin_id_p,
  input  logic             lin_done_p,
  input  logic             dma_full,
  input  logic [NPINS-1:0] modem_pins,
  output logic [SW_W-1:0]  status_q,
  output logic [SW_W-1:0]  rd_data
);
  logic [NPINS-1:0]    chg;
  logic [N_STICKY-1:0] st_set, st_clr, st_flag;
  logic                txrdy, txempty;
  logic [SW_W-1:0]     snap;

  ssw_modem_chg #(.NP(NPINS), .STAGES(SYNC_STAGES)) u_chg (
    .clk(clk), .rst(rst), .pins(modem_pins), .rd_en(rd_en), .chg_o(chg));

  always_comb begin
    st_set          = '0;
    st_set[S_PAR]   = mdrop ? addr_char_p : par_err_p;
    st_set[S_FRM]   = stop_low_p;
    st_set[S_OVR]   = ovr_p;
    st_set[S_BRK]   = brk_p;
    st_set[S_TMO]   = tmo_expire_p;
    st_set[S_REP]   = spi_slave ? unre_p : iter_p;
    st_set[S_NACK]  = nack_p;
    st_set[S_LID]   = lin_id_p;
    st_set[S_LDONE] = lin_done_p;
    st_clr          = {N_STICKY{cmd_rst_sta}};
    st_clr[S_TMO]   = cmd_sttto;
    st_clr[S_NACK]  = cmd_rst_nack;
  end

  ssw_sticky_bank #(.N(N_STICKY)) u_sticky (
    .clk(clk), .rst(rst), .set_i(st_set), .clr_i(st_clr), .flag_o(st_flag));

  ssw_tx_level u_tx (
    .tx_en(tx_en), .thr_full(thr_full), .tsr_busy(tsr_busy),
    .brk_pend(brk_pend), .txrdy(txrdy), .txempty(txempty));

  always_comb begin
    snap            = '0;
    snap[B_TXRDY]   = txrdy;
    snap[B_BRK]     = st_flag[S_BRK];
    snap[B_OVR]     = st_flag[S_OVR];
    snap[B_FRM]     = st_flag[S_FRM];
    snap[B_PAR]     = st_flag[S_PAR];
    snap[B_TMO]     = st_flag[S_TMO] & ~tmo_zero;
    snap[B_TXEMPTY] = txempty;
    snap[B_REP]     = st_flag[S_REP];
    snap[B_BUFFUL]  = dma_full;
    snap[B_NACK]    = st_flag[S_NACK];
    snap[B_LID]     = st_flag[S_LID];
    snap[B_LDONE]   = st_flag[S_LDONE];
    snap[B_CHG0 +: NPINS] = chg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      rd_data  <= '0;
    end else begin
      status_q <= snap;
      if (rd_en) rd_data <= snap;
    end
  end

  AST_NACK_SURVIVES: assert property (@(posedge clk) disable iff (rst)
    st_flag[S_NACK] && !cmd_rst_nack |=> st_flag[S_NACK]); // R3
  AST_TXRDY_GATED: assert property (@(posedge clk) disable iff (rst)
    status_q[B_TXRDY] |-> $past(tx_en && !thr_full && !brk_pend)); // R7
  AST_TMO_ZERO_MASK: assert property (@(posedge clk) disable iff (rst)
    tmo_zero |=> !status_q[B_TMO]); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R10
endmodule

// File: tb/ser_status_word_tb.sv
module ser_status_word_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1;
  logic rd_en = 0, cmd_rst_sta = 0, cmd_rst_nack = 0, cmd_sttto = 0;
  logic spi_slave = 0, mdrop = 0, tx_en = 0, thr_full = 0, tsr_busy = 0, brk_pend = 0;
  logic par_err_p = 0, addr_char_p = 0, stop_low_p = 0, ovr_p = 0, brk_p = 0;
  logic tmo_expire_p = 0, tmo_zero = 0, iter_p = 0, unre_p = 0, nack_p = 0;
  logic lin_id_p = 0, lin_done_p = 0, dma_full = 0;
  logic [3:0]  modem_pins = 0;
  logic [15:0] status_q, rd_data;

  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ser_status_word u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .cmd_rst_sta(cmd_rst_sta),
    .cmd_rst_nack(cmd_rst_nack), .cmd_sttto(cmd_sttto), .spi_slave(spi_slave),
    .mdrop(mdrop), .tx_en(tx_en), .thr_full(thr_full), .tsr_busy(tsr_busy),
    .brk_pend(brk_pend), .par_err_p(par_err_p), .addr_char_p(addr_char_p),
    .stop_low_p(stop_low_p), .ovr_p(ovr_p), .brk_p(brk_p),
    .tmo_expire_p(tmo_expire_p), .tmo_zero(tmo_zero), .iter_p(iter_p),
    .unre_p(unre_p), .nack_p(nack_p), .lin_id_p(lin_id_p),
    .lin_done_p(lin_done_p), .dma_full(dma_full), .modem_pins(modem_pins),
    .status_q(status_q), .rd_data(rd_data));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive one event pulse k for a single cycle, optionally with reset-status
  task automatic pulse(input int k, input logic with_clr);
    case (k)
      0: par_err_p = 1;   1: stop_low_p = 1;  2: ovr_p = 1;
      3: brk_p = 1;       4: lin_id_p = 1;    5: lin_done_p = 1;
      6: iter_p = 1;      7: unre_p = 1;      8: addr_char_p = 1;
      9: nack_p = 1;      default: tmo_expire_p = 1;
    endcase
    cmd_rst_sta = with_clr;
    step();
    {par_err_p, stop_low_p, ovr_p, brk_p, lin_id_p, lin_done_p} = '0;
    {iter_p, unre_p, addr_char_p, nack_p, tmo_expire_p, cmd_rst_sta} = '0;
  endtask

  task automatic strobe_rst_sta();
    cmd_rst_sta = 1; step(); cmd_rst_sta = 0;
  endtask

  function automatic int bitpos(input int k);
    case (k)
      0: return 4;  1: return 3;  2: return 2;  3: return 1;
      4: return 10; 5: return 11; default: return 7;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    chk("R11 status after reset", status_q, 16'h0000);
    chk("R11 rd_data after reset", rd_data, 16'h0000);

    // R7 R8: sweep all transmitter level combinations
    for (int v = 0; v < 16; v++) begin
      {tx_en, thr_full, tsr_busy, brk_pend} = v[3:0];
      step();
      chk("R7 txrdy", {15'b0, status_q[0]}, {15'b0, v[3] & ~v[2] & ~v[0]});
      chk("R8 txempty", {15'b0, status_q[6]}, {15'b0, v[3] & ~v[2] & ~v[1]});
    end
    {tx_en, thr_full, tsr_busy, brk_pend} = '0;

    // R9: buffer full is live
    dma_full = 1; step();
    chk("R9 bufful high", {15'b0, status_q[8]}, 16'h1);
    dma_full = 0; step();
    chk("R9 bufful low", {15'b0, status_q[8]}, 16'h0);

    // R2: each sticky flag sets, holds, clears on reset-status, set wins
    for (int k = 0; k < 7; k++) begin
      pulse(k, 0); step();
      chk("R2 sticky set", status_q, 16'h1 << bitpos(k));
      step();
      chk("R2 sticky hold", status_q, 16'h1 << bitpos(k));
      strobe_rst_sta(); step();
      chk("R2 sticky cleared", status_q, 16'h0);
      pulse(k, 1); step();
      chk("R2 set beats clear", status_q, 16'h1 << bitpos(k));
      strobe_rst_sta(); step();
    end

    // R4: mode select for bit 7
    spi_slave = 1;
    pulse(6, 0); step();
    chk("R4 iter ignored in spi slave", status_q, 16'h0);
    pulse(7, 0); step();
    chk("R4 underrun in spi slave", status_q, 16'h0080);
    strobe_rst_sta(); spi_slave = 0;
    pulse(7, 0); step();
    chk("R4 underrun ignored normal", status_q, 16'h0);

    // R5: multidrop parity
    mdrop = 1;
    pulse(0, 0); step();
    chk("R5 parity err ignored multidrop", status_q, 16'h0);
    pulse(8, 0); step();
    chk("R5 address char sets bit4", status_q, 16'h0010);
    strobe_rst_sta(); mdrop = 0;
    pulse(8, 0); step();
    chk("R5 address char ignored normal", status_q, 16'h0);

    // R3: nack clears only on its own command
    pulse(9, 0); step();
    chk("R3 nack set", status_q, 16'h0200);
    strobe_rst_sta(); step();
    chk("R3 nack survives rst_sta", status_q, 16'h0200);
    cmd_rst_nack = 1; step(); cmd_rst_nack = 0; step();
    chk("R3 nack cleared", status_q, 16'h0);

    // R6: time-out
    pulse(10, 0); step();
    chk("R6 timeout set", status_q, 16'h0020);
    strobe_rst_sta(); step();
    chk("R6 timeout survives rst_sta", status_q, 16'h0020);
    tmo_zero = 1; step();
    chk("R6 timeout masked by zero value", status_q, 16'h0);
    tmo_zero = 0; step();
    chk("R6 timeout unmasked", status_q, 16'h0020);
    cmd_sttto = 1; step(); cmd_sttto = 0; step();
    chk("R6 timeout cleared by start", status_q, 16'h0);

    // R1 R10: pin change flags, clear on read
    for (int p = 0; p < 4; p++) begin
      modem_pins[p] = ~modem_pins[p];
      repeat (4) step();
      chk("R1 change flag set", status_q, 16'h1000 << p);
      rd_en = 1; step(); rd_en = 0;
      chk("R10 rd_data pre-clear", rd_data, 16'h1000 << p);
      step();
      chk("R1 change flag cleared by read", status_q, 16'h0);
      repeat (2) step();
      chk("R10 rd_data held", rd_data, 16'h1000 << p);
    end

    // R1: change coinciding with a read is kept
    modem_pins[0] = ~modem_pins[0];
    step(); step();
    rd_en = 1; step(); rd_en = 0;
    chk("R10 rd_data before coincident change", rd_data, 16'h0);
    step();
    chk("R1 change kept on coincident read", status_q, 16'h1000);
    rd_en = 1; step(); rd_en = 0; step();
    chk("R1 cleared after second read", status_q, 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule